// File: doc/BRIEF.md
# Bit-Interleaved Four-Source TDM Serializer

This block merges several byte-wide sample streams into one serial line. Each frame carries one sample from every source. A frame opens with a single synchronisation bit. The data bits follow, interleaved one bit at a time across the sources: the most significant bit of every source comes first, then the next bit of every source, down to bit 0. The default build has four 8-bit sources, so a frame is 33 bits long. The bit period comes from the system clock through a divider. The defaults give about 330 kbit/s from 50 MHz, which is 10,000 frames per second.

Software or an upstream converter presents a new set of samples with a one-cycle strobe whenever it has one. The block keeps these samples in a holding register and copies them into the active register only when a new frame's sync bit goes out. A frame already on the line therefore never mixes old and new samples. If no strobe arrives during a frame, the next frame repeats the previous samples. A frame-start flag stays high for the whole period of the sync bit, so a receiver or a test fixture can align to the frame.

Top module: `tdm_bit_mux`

## Requirements
- R1: Every frame is 1 + N_SRC*SAMPLE_W bit periods long (33 by default). The sync bit is the first of these. frame_start_o is 1 for the whole sync bit period and 0 for every data bit period.
- R2: The sync bit is 1 in the first frame after reset and alternates between 0 and 1 on each frame after that.
- R3: Source s occupies sample_i[s*SAMPLE_W +: SAMPLE_W]. The data bits go out with bit index SAMPLE_W-1 first and bit 0 last. Within each bit index, source 0 goes first and source N_SRC-1 goes last.
- R4: bit_en_o is a one-cycle pulse that repeats every CLK_DIV clock cycles. bit_o and frame_start_o change only on cycles in which bit_en_o is 1, and keep their value between pulses.
- R5: A sample set loaded while a frame is on the line does not change that frame. It is sent from the next frame onward.
- R6: When load_i pulses more than once within one frame, the next frame carries the last sample set loaded.
- R7: When there is no load during a frame, the next frame carries the same samples again.
- R8: During reset, bit_o, bit_en_o and frame_start_o are 0 and the stored samples are cleared. The first bit_en_o pulse comes CLK_DIV clock edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | N_SRC*SAMPLE_W | Packed samples; source s at bits [s*SAMPLE_W +: SAMPLE_W] |
| load_i | input | 1 | Captures sample_i into the holding register |
| bit_o | output | 1 | Serial line bit |
| bit_en_o | output | 1 | One-cycle pulse marking a new bit on bit_o |
| frame_start_o | output | 1 | High while the sync bit is on the line |

## Verification
The hardest case to reach is a load that lands while a frame is part-way out. A fault there would show up as a mix of samples inside one frame, which only a bit-exact comparison over the whole frame can see. The stimulus waits until the monitor has seen a frame's sync bit and then loads new samples in the middle of that frame. Some frames get two loads, one frame gets none, and the patterns are all-ones, all-zeros and mixed. The bench predicts every 33-bit frame from the requirements and compares it bit by bit with the line.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int unsigned SYS_CLK_HZ  = 50_000_000;
  localparam int unsigned FRAME_HZ    = 10_000;
  localparam int unsigned N_SRC_DEF   = 4;
  localparam int unsigned SAMPLE_W_DEF = 8;

  function automatic int unsigned bits_per_frame(int unsigned n_src, int unsigned w);
    return n_src * w + 1;
  endfunction

  function automatic int unsigned clk_per_bit(int unsigned n_src, int unsigned w);
    return SYS_CLK_HZ / (FRAME_HZ * bits_per_frame(n_src, w));
  endfunction
endpackage

// File: rtl/tdm_bit_tick.sv
module tdm_bit_tick #(
  parameter int unsigned DIV = 151
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_gap_chk
      assert_tick_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/tdm_frame_buf.sv
module tdm_frame_buf #(
  parameter int unsigned N_SRC    = 4,
  parameter int unsigned SAMPLE_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [N_SRC*SAMPLE_W-1:0] sample_i,
  input  logic                      swap_i,
  output logic [N_SRC*SAMPLE_W-1:0] act_o
);
  localparam int unsigned FRAME_W = N_SRC * SAMPLE_W;

  logic [FRAME_W-1:0] pend_q;
  logic [FRAME_W-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= '0;
    else if (load_i) pend_q <= sample_i;
  end

  // active set only moves at the frame boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= '0;
    else if (swap_i) act_q <= pend_q;
  end

  assign act_o = act_q;

  assert_active_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swap_i |=> $stable(act_o));
endmodule

// File: rtl/tdm_serializer.sv
module tdm_serializer #(
  parameter int unsigned N_SRC    = 4,
  parameter int unsigned SAMPLE_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  input  logic [N_SRC*SAMPLE_W-1:0] act_i,
  output logic                      swap_o,
  output logic                      bit_o,
  output logic                      bit_en_o,
  output logic                      frame_start_o
);
  localparam int unsigned SRC_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int unsigned BIDX_W = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1;
  localparam logic [SRC_W-1:0]  SRC_LAST = SRC_W'(N_SRC - 1);
  localparam logic [BIDX_W-1:0] BIT_TOP  = BIDX_W'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] slice [N_SRC];

  genvar s;
  generate
    for (s = 0; s < N_SRC; s++) begin : g_slice
      assign slice[s] = act_i[s*SAMPLE_W +: SAMPLE_W];
    end
  endgenerate

  logic              in_sync_q;
  logic              sync_q;
  logic [SRC_W-1:0]  src_q;
  logic [BIDX_W-1:0] bidx_q;
  logic              bit_q, en_q, fs_q;
  logic              data_bit;

  assign data_bit = slice[src_q][bidx_q];
  assign swap_o   = tick_i && in_sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_sync_q <= 1'b1;
      sync_q    <= 1'b1;
      src_q     <= '0;
      bidx_q    <= BIT_TOP;
      bit_q     <= 1'b0;
      en_q      <= 1'b0;
      fs_q      <= 1'b0;
    end else begin
      en_q <= tick_i;
      if (tick_i) begin
        if (in_sync_q) begin
          bit_q     <= sync_q;
          fs_q      <= 1'b1;
          sync_q    <= ~sync_q;
          in_sync_q <= 1'b0;
          src_q     <= '0;
          bidx_q    <= BIT_TOP;
        end else begin
          bit_q <= data_bit;
          fs_q  <= 1'b0;
          if (src_q == SRC_LAST) begin
            src_q <= '0;
            if (bidx_q == '0) in_sync_q <= 1'b1;
            else              bidx_q    <= bidx_q - 1'b1;
          end else begin
            src_q <= src_q + 1'b1;
          end
        end
      end
    end
  end

  assign bit_o         = bit_q;
  assign bit_en_o      = en_q;
  assign frame_start_o = fs_q;

  assert_bit_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_o |-> $stable(bit_o));
  assert_fs_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_o |-> $stable(frame_start_o));
  assert_fs_on_bit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_start_o) |-> bit_en_o);
  assert_src_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_q <= SRC_LAST);
endmodule

// File: rtl/tdm_bit_mux.sv
module tdm_bit_mux
  import tdm_pkg::*;
#(
  parameter int unsigned N_SRC    = N_SRC_DEF,
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
  parameter int unsigned CLK_DIV  = clk_per_bit(N_SRC_DEF, SAMPLE_W_DEF)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_SRC*SAMPLE_W-1:0] sample_i,
  input  logic                      load_i,
  output logic                      bit_o,
  output logic                      bit_en_o,
  output logic                      frame_start_o
);
  localparam int unsigned FRAME_W = N_SRC * SAMPLE_W;

  logic               tick;
  logic               swap;
  logic [FRAME_W-1:0] act;

  tdm_bit_tick #(.DIV(CLK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  tdm_frame_buf #(.N_SRC(N_SRC), .SAMPLE_W(SAMPLE_W)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .sample_i (sample_i),
    .swap_i   (swap),
    .act_o    (act)
  );

  tdm_serializer #(.N_SRC(N_SRC), .SAMPLE_W(SAMPLE_W)) u_ser (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick),
    .act_i         (act),
    .swap_o        (swap),
    .bit_o         (bit_o),
    .bit_en_o      (bit_en_o),
    .frame_start_o (frame_start_o)
  );
endmodule

// File: tb/sim_tdm_bit_mux.sv
module sim_tdm_bit_mux;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int NS         = 4;
  localparam int W          = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NS*W-1:0] sample = '0;
  logic            load = 1'b0;
  logic            bit_o, bit_en, fs;

  int checks = 0;
  int fails  = 0;
  int frames_seen = 0;
  int gap = 0;
  int pulses = 0;
  bit exp_sync = 1'b1;
  bit exp_bit_q [$];
  bit exp_fs_q  [$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_bit_mux #(.N_SRC(NS), .SAMPLE_W(W), .CLK_DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .load_i(load),
    .bit_o(bit_o), .bit_en_o(bit_en), .frame_start_o(fs)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // driver side: expected frame for given samples (R1,R2,R3)
  task automatic push_frame(input logic [NS*W-1:0] v);
    exp_bit_q.push_back(exp_sync);
    exp_fs_q.push_back(1'b1);
    exp_sync = ~exp_sync;
    for (int b = W-1; b >= 0; b--)
      for (int s = 0; s < NS; s++) begin
        exp_bit_q.push_back(v[s*W + b]);
        exp_fs_q.push_back(1'b0);
      end
  endtask

  task automatic load_set(input logic [NS*W-1:0] v);
    @(negedge clk);
    sample = v;
    load   = 1'b1;
    @(negedge clk);
    load   = 1'b0;
    sample = '0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      gap++;
      if (bit_en) begin
        pulses++;
        if (pulses == 1) check(gap == DIV + 1, "R8 first pulse delay", gap, DIV + 1);
        else             check(gap == DIV, "R4 pulse spacing", gap, DIV);
        gap = 0;
        if (exp_bit_q.size() == 0) begin
          check(1'b0, "R1 unexpected bit", 0, 1);
        end else begin
          bit eb, ef;
          eb = exp_bit_q.pop_front();
          ef = exp_fs_q.pop_front();
          check(bit_o == eb, "R3/R5 line bit", int'(bit_o), int'(eb));
          check(fs == ef, "R1 frame_start", int'(fs), int'(ef));
        end
        if (fs) frames_seen++;
      end else if (pulses > 0) begin
        check(gap < DIV, "R4 missing pulse", gap, DIV - 1);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check(bit_o == 1'b0, "R8 reset bit_o", int'(bit_o), 0);
    check(bit_en == 1'b0, "R8 reset bit_en_o", int'(bit_en), 0);
    check(fs == 1'b0, "R8 reset frame_start_o", int'(fs), 0);
    @(posedge clk);
    #(CLK_PERIOD/4);
    rst_n = 1'b1;
    // counted from release: next negedge is gap 1, pulse seen after DIV edges
    load_set(32'h8142_C3A5);
    push_frame(32'h8142_C3A5);

    // R5: load mid-frame 0, expected only from frame 1
    wait (frames_seen == 1);
    load_set(32'h1234_5678);
    push_frame(32'h1234_5678);

    // R6: two loads in one frame, last wins
    wait (frames_seen == 2);
    load_set(32'hDEAD_BEEF);
    load_set(32'h0F1E_2D3C);
    push_frame(32'h0F1E_2D3C);

    // R7: no load, frame repeats
    wait (frames_seen == 3);
    push_frame(32'h0F1E_2D3C);

    wait (frames_seen == 4);
    load_set(32'hFFFF_FFFF);
    push_frame(32'hFFFF_FFFF);

    wait (frames_seen == 5);
    load_set(32'h0000_0000);
    push_frame(32'h0000_0000);

    wait (frames_seen == 6);
    load_set(32'h00FF_AA55);
    push_frame(32'h00FF_AA55);

    wait (exp_bit_q.size() == 0);
    done = 1'b1;
    // R2: seven frames sent, so next sync would be 0
    check(exp_sync == 1'b0, "R2 frame count parity", int'(exp_sync), 0);
    check(frames_seen == 7, "R1 frames observed", frames_seen, 7);
    finish_run();
  end
endmodule